// File: doc/BRIEF.md
# Manchester Frame Serial Receiver

This block takes one serial line and recovers data words from frames that open with a biphase-coded start bit, carry biphase-coded data bits and close with level-coded stop bits. A strobe `samp_en`, supplied from outside, fires eight times per bit period. The receiver counts these strobes to locate the two halves of every coded bit. It decides each bit by the direction of the level change at the bit's center. Whenever it sees a center transition, it re-aligns its phase counter to that transition, so bits that run a little short or a little long still decode.

The serial input passes through a synchronizer inside the block. The data length, the bit order and the stop-bit count are captured when a frame starts. After each good frame the receiver gives a one-cycle `valid_o` pulse and holds the word on `word_o` until the next good frame arrives. When a frame is malformed it gives a one-cycle `ferr_o` pulse instead. It then ignores the line until the line has stayed high for a full bit period.

Top module: `mrx_rx`

## Requirements
- R1: A data bit whose first half is low and second half is high decodes as 1. A data bit whose first half is high and second half is low decodes as 0. Each half is read at sample 2 and sample 6 of the 8 strobes in the bit.
- R2: A frame starts when the line falls while the receiver is idle. The start bit must be low in its first half and high in its second half. Any other start bit ends the frame with a `ferr_o` pulse.
- R3: `len_code_i` selects the number of data bits. Codes 0 to 4 select 5 to 9 bits. Codes 5 to 9 select 13 to 17 bits. Codes 10 to 15 select 17 bits.
- R4: When `msb_first_i` is 1, the first data bit received becomes bit length-1 of the word. When it is 0, the first data bit received becomes bit 0.
- R5: When `two_stop_i` is 0 the frame has one high stop bit, and when it is 1 the frame has two. Each stop bit is sampled at its middle. A low stop bit gives `ferr_o` and no `valid_o`. `valid_o` follows the middle of the last stop bit.
- R6: A data bit whose two halves have the same level gives a one-cycle `ferr_o` pulse and abandons the frame.
- R7: After a framing error, falling edges are ignored until the line has been sampled high on 8 consecutive strobes.
- R8: `valid_o` lasts one clock cycle. Bits of `word_o` at or above the data length are zero. `word_o` changes only when `valid_o` pulses.
- R9: Bits that last 7 or 9 strobes, split 3+4 or 5+4 around the center transition, decode correctly because of re-alignment at the center.
- R10: After reset, `valid_o` and `ferr_o` are 0 and `word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Oversampling strobe, 8 per bit period |
| line_i | input | 1 | Serial line, asynchronous, idles high |
| len_code_i | input | 4 | Data length select (see R3) |
| msb_first_i | input | 1 | 1: first data bit is the MSB |
| two_stop_i | input | 1 | 1: two stop bits expected |
| word_o | output | W | Last received word, upper bits zero |
| valid_o | output | 1 | One-cycle pulse on a good frame |
| ferr_o | output | 1 | One-cycle pulse on a framing error |

## Verification
Every length code is sent, in both bit orders and with both stop counts. A receiver that swapped the order, mis-mapped a code or left stale upper bits would return a word that differs from the scoreboard entry. Frames are sent with equal-level data halves, a start bit that stays low, and a low first or second stop bit. A receiver that accepted any of these would produce a `valid_o` where the bench expects an error. After an error, the bench drives a run of 4-sample low/high chunks. A receiver that re-armed too early would decode that run and emit outputs nobody expects. Frames whose bits are 7 and 9 strobes long are sent without stretching the start bit. Without re-alignment, the phase would slip by one strobe per bit and the data would be corrupted within a few bits.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } mrx_state_e;

    // Map the 4-bit length select onto a data-bit count.
    function automatic int mrx_len_of(input logic [3:0] code);
        int n;
        if (code <= 4'd4)      n = 5 + int'(code);
        else if (code <= 4'd9) n = 8 + int'(code);
        else                   n = 17;
        return n;
    endfunction

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mrx_len_dec.sv
module mrx_len_dec
    import mrx_pkg::*;
#(
    parameter int W     = 17,
    parameter int LEN_W = $clog2(W + 1)
) (
    input  logic [3:0]       code_i,
    output logic [LEN_W-1:0] len_o
);
    int raw;

    always_comb begin
        raw = mrx_len_of(code_i);
        if (raw > W) raw = W;
        len_o = LEN_W'(raw);
    end
endmodule

// File: rtl/mrx_bitpos.sv
module mrx_bitpos #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] idx_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             msb_i,
    output logic [CNT_W-1:0] pos_o
);
    always_comb begin
        if (msb_i) pos_o = len_i - idx_i - CNT_W'(1);
        else       pos_o = idx_i;
    end
endmodule

// File: rtl/mrx_rx.sv
module mrx_rx
    import mrx_pkg::*;
#(
    parameter int W   = 17,
    parameter int OSR = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         samp_en,
    input  logic         line_i,
    input  logic [3:0]   len_code_i,
    input  logic         msb_first_i,
    input  logic         two_stop_i,
    output logic [W-1:0] word_o,
    output logic         valid_o,
    output logic         ferr_o
);
    localparam int PH_W  = $clog2(OSR);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [PH_W-1:0] PH_S1   = PH_W'(OSR / 4);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0] PH_S2   = PH_W'((3 * OSR) / 4);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    typedef struct packed {
        mrx_state_e       st;
        logic [PH_W-1:0]  ph;
        logic [PH_W-1:0]  idle;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             msb;
        logic             two;
        logic             stop2;
        logic             h1;
        logic             prev;
        logic [W-1:0]     shreg;
        logic [W-1:0]     word;
        logic             vld;
        logic             ferr;
    } rx_reg_t;

    rx_reg_t q, n;

    logic             line_s;
    logic [CNT_W-1:0] len_w;
    logic [CNT_W-1:0] pos_w;
    logic [CNT_W-1:0] len_q;

    mrx_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    mrx_len_dec #(.W(W), .LEN_W(CNT_W)) u_len (
        .code_i (len_code_i),
        .len_o  (len_w)
    );

    mrx_bitpos #(.CNT_W(CNT_W)) u_pos (
        .idx_i (q.cnt),
        .len_i (q.len),
        .msb_i (q.msb),
        .pos_o (pos_w)
    );

    assign len_q = q.len;

    always_comb begin
        logic bad;
        n      = q;
        n.vld  = 1'b0;
        n.ferr = 1'b0;
        bad    = 1'b0;
        if (samp_en) begin
            n.prev = line_s;
            n.ph   = (q.ph == PH_LAST) ? '0 : q.ph + PH_W'(1);
            unique case (q.st)
                ST_IDLE: begin
                    n.ph = '0;
                    if (q.prev && !line_s) begin
                        n.st    = ST_START;
                        n.ph    = PH_W'(1);
                        n.len   = len_w;
                        n.msb   = msb_first_i;
                        n.two   = two_stop_i;
                        n.cnt   = '0;
                        n.shreg = '0;
                    end
                end
                ST_START, ST_DATA: begin
                    // center transition: treat this strobe as the midpoint
                    if (q.ph >= PH_MID - PH_W'(1) && q.ph <= PH_MID + PH_W'(1)
                        && line_s != q.prev)
                        n.ph = PH_MID + PH_W'(1);
                    if (q.ph == PH_S1) n.h1 = line_s;
                    if (q.ph == PH_S2) begin
                        if (q.st == ST_START) bad = !(!q.h1 && line_s);
                        else                  bad = (q.h1 == line_s);
                        if (!bad && q.st == ST_DATA) n.shreg[pos_w] = line_s;
                    end
                    if (q.ph == PH_LAST) begin
                        if (q.st == ST_START) begin
                            n.st  = ST_DATA;
                            n.cnt = '0;
                        end else if (q.cnt == q.len - CNT_W'(1)) begin
                            n.st    = ST_STOP;
                            n.stop2 = 1'b0;
                        end else begin
                            n.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (q.ph == PH_MID) begin
                        if (!line_s) begin
                            bad = 1'b1;
                        end else if (q.two && !q.stop2) begin
                            n.stop2 = 1'b1;
                        end else begin
                            n.vld  = 1'b1;
                            n.word = q.shreg;
                            n.st   = ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!line_s) begin
                        n.idle = '0;
                    end else if (q.idle == PH_LAST) begin
                        n.idle = '0;
                        n.st   = ST_IDLE;
                    end else begin
                        n.idle = q.idle + PH_W'(1);
                    end
                end
                default: n.st = ST_IDLE;
            endcase
            if (bad) begin
                n.ferr = 1'b1;
                n.st   = ST_HOLD;
                n.idle = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign word_o  = q.word;
    assign valid_o = q.vld;
    assign ferr_o  = q.ferr;
endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk #(
    parameter int W     = 17,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_en,
    input logic             vld,
    input logic             ferr,
    input logic [W-1:0]     word,
    input logic [CNT_W-1:0] len
);
    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld); // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ferr |=> !ferr); // R6
    AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld && ferr)); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((word >> len) == '0)); // R8
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> $stable(word)); // R8
    AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(samp_en)); // R5
endmodule

bind mrx_rx mrx_rx_chk #(.W(W), .CNT_W($clog2(W + 1))) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .samp_en (samp_en),
    .vld     (valid_o),
    .ferr    (ferr_o),
    .word    (word_o),
    .len     (len_q)
);

// File: tb/sim_mrx_rx.sv
module sim_mrx_rx;
    localparam int W = 17;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         samp_en = 1'b0;
    logic         line = 1'b1;
    logic [3:0]   len_code = 4'd3;
    logic         msb_first = 1'b1;
    logic         two_stop = 1'b0;
    logic [W-1:0] word;
    logic         valid;
    logic         ferr;

    int checks = 0;
    int fails  = 0;
    logic [1:0] div = '0;

    typedef struct {
        bit           is_err;
        logic [W-1:0] w;
        string        tag;
    } exp_t;
    exp_t sb[$];
    logic [W-1:0] last_word = '0;

    mrx_rx #(.W(W), .OSR(8)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_en     (samp_en),
        .line_i      (line),
        .len_code_i  (len_code),
        .msb_first_i (msb_first),
        .two_stop_i  (two_stop),
        .word_o      (word),
        .valid_o     (valid),
        .ferr_o      (ferr)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        div     <= div + 2'd1;
        samp_en <= (div == 2'd3);
    end

    function automatic int len_of(input logic [3:0] c);
        case (c)
            4'd0: return 5;   4'd1: return 6;   4'd2: return 7;
            4'd3: return 8;   4'd4: return 9;   4'd5: return 13;
            4'd6: return 14;  4'd7: return 15;  4'd8: return 16;
            4'd9: return 17;  default: return 17;
        endcase
    endfunction

    task automatic level(input logic v, input int nsamp);
        line = v;
        repeat (nsamp * 4) @(negedge clk);
    endtask

    task automatic mbit(input logic b, input int h1n, input int h2n);
        level(~b, h1n);
        level(b, h2n);
    endtask

    task automatic push(input bit e, input logic [W-1:0] w, input string tag);
        exp_t x;
        x.is_err = e;
        x.w      = w;
        x.tag    = tag;
        sb.push_back(x);
    endtask

    task automatic frame(input logic [W-1:0] data, input logic [3:0] code,
                         input logic msb, input logic two,
                         input int h1n, input int h2n, input string tag);
        int len;
        logic [W-1:0] m;
        len = len_of(code);
        m   = (W'(1) << len) - W'(1);
        len_code  = code;
        msb_first = msb;
        two_stop  = two;
        level(1'b1, 4);
        push(1'b0, data & m, tag);
        mbit(1'b1, 4, 4);
        for (int i = 0; i < len; i++) begin
            if (msb) mbit(data[len-1-i], h1n, h2n);
            else     mbit(data[i], h1n, h2n);
        end
        level(1'b1, two ? 16 : 8);
        level(1'b1, 8);
    endtask

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (valid || ferr)) begin
            if (sb.size() == 0) begin
                check(1'b0, ferr ? "R7 unexpected error" : "R7 unexpected word", word, '0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                if (x.is_err) begin
                    check(ferr && !valid, x.tag, {16'd0, valid}, {16'd0, 1'b0});
                end else begin
                    check(valid && !ferr && word == x.w, x.tag, word, x.w);
                    last_word = x.w;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(valid == 1'b0 && ferr == 1'b0 && word == '0, "R10 reset", word, '0);
        rst_n = 1'b1;
        level(1'b1, 8);

        frame(17'h000A5, 4'd3, 1'b1, 1'b0, 4, 4, "R1 R4 msb 8b");
        frame(17'h0003C, 4'd3, 1'b0, 1'b0, 4, 4, "R4 lsb 8b");
        check(word == 17'h0003C, "R8 hold", word, 17'h0003C);

        for (int c = 0; c < 16; c++)
            frame(17'h1B5A3 ^ W'(c * 37), 4'(c), c[0], c[1], 4, 4, "R3 R5 length code");

        frame(17'h1FFFF, 4'd9, 1'b1, 1'b0, 4, 4, "R1 ones");
        frame(17'h1FFFF, 4'd0, 1'b0, 1'b1, 4, 4, "R8 upper zero");
        check(word == 17'h0001F, "R8 upper zero held", word, 17'h0001F);

        // bad data bit: both halves low
        len_code = 4'd3; msb_first = 1'b1; two_stop = 1'b0;
        level(1'b1, 4);
        push(1'b1, '0, "R6 equal halves");
        mbit(1'b1, 4, 4);
        mbit(1'b1, 4, 4);
        level(1'b0, 8);
        level(1'b1, 16);
        check(word == last_word, "R6 word kept", word, last_word);

        // bad start bit: stays low
        push(1'b1, '0, "R2 start low");
        level(1'b0, 8);
        level(1'b1, 16);

        // single stop bit low
        len_code = 4'd0; msb_first = 1'b0; two_stop = 1'b0;
        level(1'b1, 4);
        push(1'b1, '0, "R5 stop low");
        mbit(1'b1, 4, 4);
        for (int i = 0; i < 5; i++) mbit(1'b1, 4, 4);
        level(1'b0, 8);
        level(1'b1, 16);

        // second stop bit low
        two_stop = 1'b1;
        level(1'b1, 4);
        push(1'b1, '0, "R5 second stop low");
        mbit(1'b1, 4, 4);
        for (int i = 0; i < 5; i++) mbit(1'b0, 4, 4);
        level(1'b1, 8);
        level(1'b0, 8);
        level(1'b1, 16);

        // error then chunks that never reach a full idle bit
        len_code = 4'd3; two_stop = 1'b0;
        level(1'b1, 4);
        push(1'b1, '0, "R7 trigger error");
        mbit(1'b1, 4, 4);
        level(1'b0, 8);
        for (int i = 0; i < 6; i++) begin
            level(1'b0, 4);
            level(1'b1, 4);
        end
        level(1'b0, 4);
        level(1'b1, 10);
        frame(17'h00069, 4'd3, 1'b1, 1'b0, 4, 4, "R7 rearmed");

        // drifting bit lengths
        frame(17'h0B3C5, 4'd8, 1'b1, 1'b0, 3, 4, "R9 short bits");
        frame(17'h04A6D, 4'd8, 1'b0, 1'b1, 5, 4, "R9 long bits");

        level(1'b1, 8);
        check(sb.size() == 0, "R5 all results seen", W'(sb.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule